// File: doc/BRIEF.md
# Background tile fetch sequencer

This block steps through the memory reads needed to build one 8-pixel strip of a tile-based background or window layer. For every tile it reads the tile number from a tile map in video RAM. In color mode it then reads an attribute byte from the second bank. Next it reads the low and the high bitplane byte of the selected pixel row. Finally it offers the two bytes to a downstream pixel FIFO with a valid/ready handshake. It then moves on to the next map column.

Every fetch step takes two clock cycles. The first cycle drives the read address and a read strobe into a synchronous RAM. The second cycle captures the returned byte. The map base, the tile data addressing mode and the pixel row are taken from the live register inputs at the moment each address is issued, so register writes in the middle of a fetch take effect at the next step. The only exception is that in color mode the pixel row is frozen when the tile number is fetched. A restart pulse at the start of a line, or where the window begins, puts the sequencer back at the tile-number step with a fresh column counter.

Top module: `bg_tile_fetcher`

## Requirements
- R1: Each fetch step lasts two cycles, with `vram_rd` high only in the first. With `push_ready` low, `push_valid` first reads high in the 7th cycle after the restart edge in mono mode (steps: tile number, low byte, high byte) and in the 9th cycle in color mode (an attribute step follows the tile number).
- R2: The map base is 0x1800. It is 0x1C00 when `bg_map_sel` is 1 and `win_active` is 0, or when `win_map_sel` is 1 and `win_active` is 1.
- R3: The pixel row is `line + scroll_y` when `win_active` is 0 and `line - win_y - win_line_ofs` when `win_active` is 1, modulo 256.
- R4: The tile number is read at map base + column + (row / 8) * 32. The 5-bit column counter advances by one after each tile number fetch and wraps from 31 to 0.
- R5: In color mode the attribute byte is read at the tile number address + 0x2000. In mono mode that step is skipped and the attribute is taken as zero.
- R6: When `tile_data_unsigned` is 1 the tile base is tile number * 16. When it is 0 the tile base is 0x1000 + (tile number as a signed byte) * 16.
- R7: Attribute bit 3 adds 0x2000 to the tile base. Attribute bit 6 replaces the fine row (row modulo 8) with 7 minus the fine row.
- R8: The low byte is read at tile base + 2 * fine row and the high byte one address above. `tile_data_unsigned` is sampled separately for each of the two byte steps.
- R9: In color mode the row used for both byte steps is the one in effect at the tile number step. In mono mode each byte step uses the row in effect when its own address is issued.
- R10: After reset `push_valid` is 0. While `push_valid` is high and `push_ready` is low, `push_valid`, `push_lo` and `push_hi` stay unchanged. An accepted push starts the next tile.
- R11: A `line_start` pulse abandons any tile in progress and restarts at the tile number step. The column is loaded with `scroll_x_tile` when `win_active` is 0, and with 0 when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | Restart pulse at line start or window start |
| cur_line | input | 8 | Current display line |
| scroll_y | input | 8 | Vertical background scroll |
| scroll_x_tile | input | 5 | Horizontal scroll divided by 8 |
| win_y | input | 8 | Window top line |
| win_line_ofs | input | 8 | Window line offset |
| bg_map_sel | input | 1 | Upper map for the background |
| win_map_sel | input | 1 | Upper map for the window |
| tile_data_unsigned | input | 1 | Unsigned tile numbering at base 0 |
| win_active | input | 1 | Fetching window tiles |
| color_mode | input | 1 | Color mode: attribute fetch and row latch |
| vram_addr | output | 14 | Video RAM read address |
| vram_rd | output | 1 | Read strobe, data returns next cycle |
| vram_rdata | input | 8 | Read data from video RAM |
| push_valid | output | 1 | Bitplane pair offered to the FIFO |
| push_ready | input | 1 | FIFO accepts the pair |
| push_lo | output | 8 | Low bitplane byte |
| push_hi | output | 8 | High bitplane byte |

## Verification
The assertions assume that `color_mode` is held steady across a tile. They also assume that the RAM returns the addressed byte in the cycle after `vram_rd`. The bench therefore changes the mode only while the FIFO is stalled, just before a restart, and its RAM model registers data one cycle after the strobe. Register changes in the middle of a fetch are applied on the falling edge between the steps they are meant to split, because the expected rows and modes are worked out per step from that placement. Extra pushes are blocked by holding `push_ready` low outside each run, so any push that was not predicted is flagged.

// File: rtl/bgf_pkg.sv
package bgf_pkg;
  typedef enum logic [2:0] {
    ST_IDX  = 3'd0,
    ST_ATTR = 3'd1,
    ST_LO   = 3'd2,
    ST_HI   = 3'd3,
    ST_PUSH = 3'd4
  } fetch_state_e;
endpackage

// File: rtl/bgf_row_calc.sv
module bgf_row_calc #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] cur_line,
  input  logic [DW-1:0] scroll_y,
  input  logic [DW-1:0] win_y,
  input  logic [DW-1:0] win_line_ofs,
  input  logic          win_active,
  output logic [DW-1:0] row
);
  always_comb begin
    if (win_active) row = cur_line - win_y - win_line_ofs;
    else            row = cur_line + scroll_y;
  end
endmodule

// File: rtl/bgf_addr_gen.sv
module bgf_addr_gen
  import bgf_pkg::*;
#(
  parameter int DW  = 8,
  parameter int AW  = 14,
  parameter int TXW = 5,
  parameter int FRW = 3,
  parameter logic [AW-1:0] MAP_BASE_A  = 14'h1800,
  parameter logic [AW-1:0] MAP_BASE_B  = 14'h1C00,
  parameter logic [AW-1:0] BANK_OFS    = 14'h2000,
  parameter logic [AW-1:0] SIGNED_BASE = 14'h1000
) (
  input  fetch_state_e        state,
  input  logic                win_active,
  input  logic                bg_map_sel,
  input  logic                win_map_sel,
  input  logic                tile_data_unsigned,
  input  logic [TXW-1:0]      tile_x,
  input  logic [DW-FRW-1:0]   map_row_coarse,
  input  logic [AW-1:0]       map_addr_latched,
  input  logic [DW-1:0]       tile_idx,
  input  logic                attr_bank,
  input  logic                attr_flip,
  input  logic [FRW-1:0]      fine_row,
  output logic [AW-1:0]       map_addr,
  output logic [AW-1:0]       vram_addr
);
  // bytes per tile = two planes of (1<<FRW) rows
  localparam int TILE_SHIFT = FRW + 1;

  logic          upper_map;
  logic [AW-1:0] tile_base;
  logic [AW-1:0] data_addr;
  logic [FRW-1:0] eff_fine;

  always_comb begin
    upper_map = win_active ? win_map_sel : bg_map_sel;
    map_addr  = (upper_map ? MAP_BASE_B : MAP_BASE_A) + AW'(tile_x)
              + (AW'(map_row_coarse) << TXW);

    if (tile_data_unsigned)
      tile_base = AW'(tile_idx) << TILE_SHIFT;
    else
      tile_base = SIGNED_BASE + (AW'($signed(tile_idx)) << TILE_SHIFT);

    eff_fine  = fine_row ^ {FRW{attr_flip}};
    data_addr = tile_base + (attr_bank ? BANK_OFS : '0)
              + (AW'(eff_fine) << 1) + AW'(state == ST_HI);

    case (state)
      ST_IDX:  vram_addr = map_addr;
      ST_ATTR: vram_addr = map_addr_latched + BANK_OFS;
      default: vram_addr = data_addr;
    endcase
  end
endmodule

// File: rtl/bgf_seq.sv
module bgf_seq
  import bgf_pkg::*;
#(
  parameter int DW  = 8,
  parameter int AW  = 14,
  parameter int TXW = 5,
  parameter int FRW = 3,
  parameter int ATTR_BANK_BIT = 3,
  parameter int ATTR_FLIP_BIT = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            line_start,
  input  logic            win_active,
  input  logic            color_mode,
  input  logic [TXW-1:0]  scroll_x_tile,
  input  logic [FRW-1:0]  live_fine,
  input  logic [AW-1:0]   map_addr,
  input  logic [DW-1:0]   vram_rdata,
  input  logic            push_ready,
  output fetch_state_e    state,
  output logic [TXW-1:0]  tile_x,
  output logic [FRW-1:0]  fine_row,
  output logic [DW-1:0]   tile_idx,
  output logic            attr_bank,
  output logic            attr_flip,
  output logic [AW-1:0]   map_addr_q,
  output logic            vram_rd,
  output logic            push_valid,
  output logic [DW-1:0]   push_lo,
  output logic [DW-1:0]   push_hi
);
  logic           phase_q;
  logic [FRW-1:0] fine_q;
  logic [DW-1:0]  lo_q, hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDX;
      phase_q    <= 1'b0;
      tile_x     <= '0;
      fine_q     <= '0;
      tile_idx   <= '0;
      attr_bank  <= 1'b0;
      attr_flip  <= 1'b0;
      map_addr_q <= '0;
      lo_q       <= '0;
      hi_q       <= '0;
    end else if (line_start) begin
      state   <= ST_IDX;
      phase_q <= 1'b0;
      tile_x  <= win_active ? '0 : scroll_x_tile;
    end else begin
      if (state != ST_PUSH) phase_q <= ~phase_q;
      case (state)
        ST_IDX: begin
          if (!phase_q) begin
            fine_q     <= live_fine;
            map_addr_q <= map_addr;
          end else begin
            tile_idx <= vram_rdata;
            tile_x   <= tile_x + 1'b1;
            if (color_mode) state <= ST_ATTR;
            else begin
              attr_bank <= 1'b0;
              attr_flip <= 1'b0;
              state     <= ST_LO;
            end
          end
        end
        ST_ATTR: if (phase_q) begin
          attr_bank <= vram_rdata[ATTR_BANK_BIT];
          attr_flip <= vram_rdata[ATTR_FLIP_BIT];
          state     <= ST_LO;
        end
        ST_LO: if (phase_q) begin
          lo_q  <= vram_rdata;
          state <= ST_HI;
        end
        ST_HI: if (phase_q) begin
          hi_q  <= vram_rdata;
          state <= ST_PUSH;
        end
        default: if (push_ready) begin
          state   <= ST_IDX;
          phase_q <= 1'b0;
        end
      endcase
    end
  end

  assign fine_row   = color_mode ? fine_q : live_fine;
  assign vram_rd    = (state != ST_PUSH) && !phase_q;
  assign push_valid = (state == ST_PUSH);
  assign push_lo    = lo_q;
  assign push_hi    = hi_q;

  // R1: reads come at most every other cycle
  assert_read_spacing_R1: assert property (@(posedge clk) disable iff (rst)
    (vram_rd && !line_start) |=> !vram_rd);
  // R10: an offered pair is held while stalled
  assert_push_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (push_valid && !push_ready && !line_start) |=>
      (push_valid && $stable(push_lo) && $stable(push_hi)));
  // R4: column advances once per tile number fetch
  assert_col_step_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDX && phase_q && !line_start) |=> (tile_x == $past(tile_x) + 1'b1));
  // R5: mono mode goes straight from tile number to low byte
  assert_attr_skip_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDX && phase_q && !color_mode && !line_start) |=>
      (state == ST_LO && !attr_bank && !attr_flip));
  // R9: latched row changes only during the tile number step
  assert_row_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDX) |=> $stable(fine_q));
  // R11: restart returns to the first cycle of the tile number step
  assert_restart_R11: assert property (@(posedge clk) disable iff (rst)
    line_start |=> (state == ST_IDX && vram_rd));
endmodule

// File: rtl/bg_tile_fetcher.sv
module bg_tile_fetcher
  import bgf_pkg::*;
#(
  parameter int DW  = 8,
  parameter int AW  = 14,
  parameter int TXW = 5,
  parameter int FRW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           line_start,
  input  logic [DW-1:0]  cur_line,
  input  logic [DW-1:0]  scroll_y,
  input  logic [TXW-1:0] scroll_x_tile,
  input  logic [DW-1:0]  win_y,
  input  logic [DW-1:0]  win_line_ofs,
  input  logic           bg_map_sel,
  input  logic           win_map_sel,
  input  logic           tile_data_unsigned,
  input  logic           win_active,
  input  logic           color_mode,
  output logic [AW-1:0]  vram_addr,
  output logic           vram_rd,
  input  logic [DW-1:0]  vram_rdata,
  output logic           push_valid,
  input  logic           push_ready,
  output logic [DW-1:0]  push_lo,
  output logic [DW-1:0]  push_hi
);
  fetch_state_e   state;
  logic [DW-1:0]  live_row;
  logic [TXW-1:0] tile_x;
  logic [FRW-1:0] fine_row;
  logic [DW-1:0]  tile_idx;
  logic           attr_bank, attr_flip;
  logic [AW-1:0]  map_addr, map_addr_q;

  bgf_row_calc #(.DW(DW)) u_row (
    .cur_line(cur_line), .scroll_y(scroll_y), .win_y(win_y),
    .win_line_ofs(win_line_ofs), .win_active(win_active), .row(live_row)
  );

  bgf_addr_gen #(.DW(DW), .AW(AW), .TXW(TXW), .FRW(FRW)) u_addr (
    .state(state), .win_active(win_active), .bg_map_sel(bg_map_sel),
    .win_map_sel(win_map_sel), .tile_data_unsigned(tile_data_unsigned),
    .tile_x(tile_x), .map_row_coarse(live_row[DW-1:FRW]),
    .map_addr_latched(map_addr_q), .tile_idx(tile_idx),
    .attr_bank(attr_bank), .attr_flip(attr_flip), .fine_row(fine_row),
    .map_addr(map_addr), .vram_addr(vram_addr)
  );

  bgf_seq #(.DW(DW), .AW(AW), .TXW(TXW), .FRW(FRW)) u_seq (
    .clk(clk), .rst(rst), .line_start(line_start), .win_active(win_active),
    .color_mode(color_mode), .scroll_x_tile(scroll_x_tile),
    .live_fine(live_row[FRW-1:0]), .map_addr(map_addr),
    .vram_rdata(vram_rdata), .push_ready(push_ready), .state(state),
    .tile_x(tile_x), .fine_row(fine_row), .tile_idx(tile_idx),
    .attr_bank(attr_bank), .attr_flip(attr_flip), .map_addr_q(map_addr_q),
    .vram_rd(vram_rd), .push_valid(push_valid), .push_lo(push_lo),
    .push_hi(push_hi)
  );
endmodule

// File: tb/bg_tile_fetcher_test.sv
`timescale 1ns/1ps
module bg_tile_fetcher_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_start = 1'b0;
  logic [7:0] cur_line = '0, scroll_y = '0, win_y = '0, win_line_ofs = '0;
  logic [4:0] scroll_x_tile = '0;
  logic [2:0] ctl = 3'b000;  // {tile_data_unsigned, win_map_sel, bg_map_sel}
  logic win_active = 1'b0, color_mode = 1'b0, push_ready = 1'b0;
  logic [13:0] vram_addr;
  logic vram_rd, push_valid;
  logic [7:0] vram_rdata = '0, push_lo, push_hi;

  logic [7:0] mem [0:16383];
  logic [15:0] q_exp[$];
  string q_tag[$];
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bg_tile_fetcher uut (
    .clk(clk), .rst(rst), .line_start(line_start), .cur_line(cur_line),
    .scroll_y(scroll_y), .scroll_x_tile(scroll_x_tile), .win_y(win_y),
    .win_line_ofs(win_line_ofs), .bg_map_sel(ctl[0]), .win_map_sel(ctl[1]),
    .tile_data_unsigned(ctl[2]), .win_active(win_active),
    .color_mode(color_mode), .vram_addr(vram_addr), .vram_rd(vram_rd),
    .vram_rdata(vram_rdata), .push_valid(push_valid),
    .push_ready(push_ready), .push_lo(push_lo), .push_hi(push_hi)
  );

  always @(posedge clk) if (vram_rd) vram_rdata <= mem[vram_addr];

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && push_valid && push_ready) begin
      if (q_exp.size() == 0) chk("R10 unexpected push", {push_lo, push_hi}, 32'hFFFF_FFFF);
      else begin
        logic [15:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        chk(t, {16'h0, push_lo, push_hi}, {16'h0, e});
      end
    end
  end

  function automatic logic [7:0] row_of(input logic w, input logic [7:0] sy);
    return w ? (cur_line - win_y - win_line_ofs) : (cur_line + sy);
  endfunction

  function automatic logic [13:0] daddr(input logic [7:0] idx, input logic [7:0] at,
                                        input logic u, input logic [7:0] r, input logic hb);
    logic [13:0] b;
    logic [2:0] f;
    b = u ? ({6'b0, idx} << 4) : (14'h1000 + ({{6{idx[7]}}, idx} << 4));
    if (at[3]) b = b + 14'h2000;
    f = r[2:0] ^ {3{at[6]}};
    return b + {10'b0, f, 1'b0} + {13'b0, hb};
  endfunction

  function automatic logic [15:0] exp_pair(input logic w, input logic col,
      input logic [2:0] ci, input logic [2:0] cl, input logic [2:0] ch,
      input logic [7:0] ri, input logic [7:0] rl, input logic [7:0] rh, input logic [4:0] tx);
    logic [13:0] m;
    logic [7:0] idx, at;
    m = (((w ? ci[1] : ci[0]) ? 14'h1C00 : 14'h1800)) + {9'b0, tx} + ({9'b0, ri[7:3]} << 5);
    idx = mem[m];
    at = col ? mem[m + 14'h2000] : 8'h00;
    return {mem[daddr(idx, at, cl[2], rl, 1'b0)], mem[daddr(idx, at, ch[2], rh, 1'b1)]};
  endfunction

  task automatic start_line();
    @(negedge clk) line_start = 1'b1;
    @(posedge clk);
    @(negedge clk) line_start = 1'b0;
  endtask

  task automatic expect_line(input int nt, input string tag);
    logic [4:0] tx;
    logic [7:0] r;
    tx = win_active ? 5'd0 : scroll_x_tile;
    r = row_of(win_active, scroll_y);
    for (int i = 0; i < nt; i++) begin
      q_exp.push_back(exp_pair(win_active, color_mode, ctl, ctl, ctl, r, r, r, tx));
      q_tag.push_back(tag);
      tx = tx + 5'd1;
    end
  endtask

  task automatic drain();
    while (q_exp.size() != 0) @(negedge clk);
    @(negedge clk) push_ready = 1'b0;
  endtask

  task automatic run_line(input int nt, input string tag);
    expect_line(nt, tag);
    start_line();
    push_ready = 1'b1;
    drain();
  endtask

  task automatic timing_check(input int exp_cycle, input string tag);
    int k;
    expect_line(1, tag);
    push_ready = 1'b0;
    start_line();
    k = 1;
    while (!push_valid && k < 20) begin
      @(negedge clk);
      k++;
    end
    chk(tag, k, exp_cycle);
    push_ready = 1'b1;
    drain();
  endtask

  // change a register between the low and high byte address cycles
  task automatic mid_change(input logic [7:0] new_sy, input logic [2:0] new_ctl, input string tag);
    logic [7:0] r0, r1;
    logic [2:0] c0;
    r0 = row_of(win_active, scroll_y);
    r1 = row_of(win_active, new_sy);
    c0 = ctl;
    q_exp.push_back(exp_pair(win_active, color_mode, c0, c0, new_ctl, r0, r0,
                             color_mode ? r0 : r1, win_active ? 5'd0 : scroll_x_tile));
    q_tag.push_back(tag);
    start_line();
    push_ready = 1'b1;
    repeat (color_mode ? 5 : 3) @(posedge clk);
    @(negedge clk);
    scroll_y = new_sy;
    ctl = new_ctl;
    drain();
  endtask

  initial begin
    for (int a = 0; a < 16384; a++) mem[a] = 8'((a * 7) ^ (a >> 6) ^ 8'h5A);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset push_valid", {31'b0, push_valid}, 0);
    rst = 1'b0;

    // pacing
    cur_line = 8'h25; scroll_y = 8'h13; ctl = 3'b100;
    timing_check(7, "R1 mono push cycle");
    color_mode = 1'b1;
    timing_check(9, "R1 color push cycle");
    color_mode = 1'b0;

    // background, column wrap from 30
    scroll_x_tile = 5'd30;
    run_line(4, "R3 R4 R11 bg row and column wrap");
    // upper background map, signed tile data
    ctl = 3'b001; scroll_x_tile = 5'd3; scroll_y = 8'hF7;
    run_line(3, "R2 R6 upper bg map signed data");
    // window
    win_active = 1'b1; win_y = 8'h10; win_line_ofs = 8'h02; cur_line = 8'h40;
    ctl = 3'b110; scroll_x_tile = 5'd9;
    run_line(3, "R2 R3 R11 window upper map");
    ctl = 3'b001;
    run_line(2, "R2 window ignores bg map select");
    win_active = 1'b0;

    // color mode attributes
    color_mode = 1'b1; ctl = 3'b100; scroll_x_tile = 5'd5; cur_line = 8'h63;
    run_line(6, "R5 R7 color attr unsigned");
    ctl = 3'b000;
    run_line(6, "R5 R7 color attr signed");

    // row capture
    scroll_y = 8'h00; cur_line = 8'h21;
    mid_change(8'h03, ctl, "R9 color row latched");
    color_mode = 1'b0; scroll_y = 8'h00;
    mid_change(8'h05, ctl, "R9 mono row live");
    // tile mode per byte step
    ctl = 3'b100;
    mid_change(scroll_y, 3'b000, "R8 mono tile mode per byte");
    ctl = 3'b000;
    mid_change(scroll_y, 3'b100, "R8 mono tile mode per byte back");

    // stall hold
    begin
      logic [15:0] held;
      expect_line(1, "R10 stalled pair");
      push_ready = 1'b0;
      start_line();
      repeat (12) @(negedge clk);
      chk("R10 valid while stalled", {31'b0, push_valid}, 1);
      held = {push_lo, push_hi};
      repeat (4) @(negedge clk);
      chk("R10 held data", {16'b0, push_lo, push_hi}, {16'b0, held});
      push_ready = 1'b1;
      drain();
    end

    // restart in the middle of a tile
    scroll_x_tile = 5'd12;
    start_line();
    repeat (3) @(negedge clk);
    scroll_x_tile = 5'd20;
    run_line(2, "R11 restart abandons tile");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule